// File: doc/BRIEF.md
# Multiplexed LCD Common and Segment Level Sequencer

This block drives a passive multiplexed LCD with up to four common lines and sixty segment lines. It counts oscillator clocks to time each common phase, selects one common per phase, and puts out a two-bit level code on every common and segment line. An external resistor or buffer ladder turns each code into a voltage. The polarity of every frame is the inverse of the one before it, so no pixel sees a DC voltage on average.

Display data comes from a four-row output latch. The latch is loaded from a display memory image only when a load request has been made, and only at a frame boundary, so a frame never mixes old and new data. Software selects the duty (two, three or four commons) and one of four frame-rate dividers. The bias scheme follows the duty. Blanking forces every line to the top rail and leaves the latch contents unchanged.

Top module: `lcd_mux_seq`

## Requirements
- R1: Each common phase lasts 128·2^k clocks, where k is `frame_code`. Phases run 0, 1, … n−1 and then return to 0, so a frame lasts n phases.
- R2: `duty_sel` 00 and 01 give n = 2 commons (COM0–COM1), 10 gives n = 3, and 11 gives n = 4.
- R3: The frame polarity is 0 in the first frame after reset and inverts at the end of every frame.
- R4: Level codes are 0 = bottom rail, 1 = lower intermediate, 2 = upper intermediate, 3 = top rail. At polarity 0 a selected common is at 3 and a lit segment is at 0. At polarity 1 a selected common is at 0 and a lit segment is at 3. For n = 2 (half bias): unselected commons are at 1, and a dark segment is at 3 when polarity is 0 and at 0 when polarity is 1. For n ≥ 3 (third bias): unselected commons are at 1 when polarity is 0 and at 2 when polarity is 1, and a dark segment is at 2 when polarity is 0 and at 1 when polarity is 1. Code 2 never appears at n = 2.
- R5: When `disp_on` is low or `disp_off_n` is low, every common and segment output is 3. Latch contents are kept and reappear once blanking ends.
- R6: After reset the phase, polarity, latch and pending request are all zero. With `disp_on` low, every output is 3.
- R7: A `latch_req` pulse is remembered and applied at the next frame end. A request that arrives in the frame-end cycle itself is applied at that boundary. The latch copies `ram_data` as it stands in the boundary cycle. Changes to `ram_data` at any other time have no effect on the outputs.
- R8: Commons at index n or higher are held at the unselected-common level of R4.
- R9: During phase p, segment s is lit when latch bit p·60+s (that is, `ram_data` bit p·60+s at load time) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one count per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_sel | input | 2 | Duty selection (R2) |
| frame_code | input | 2 | Frame-rate divider exponent k |
| disp_on | input | 1 | Display enable; low blanks all lines |
| disp_off_n | input | 1 | Display-off input, active low |
| latch_req | input | 1 | One-cycle request to load the latch at the next frame end |
| ram_data | input | 240 | Display memory image, bit c·60+s for common c, segment s |
| com_lvl | output | 8 | Level codes, 2 bits per common, common c at bits 2c+1:2c |
| seg_lvl | output | 120 | Level codes, 2 bits per segment, segment s at bits 2s+1:2s |

## Verification
The latch load and the frame end can fall in the same cycle. Both the polarity flip and the row change then meet a load request that arrives in exactly that cycle. The bench watches its own model's counters and raises `latch_req` for the single clock that ends a frame, with a new memory pattern applied at the same time. It also raises a request mid-frame and changes `ram_data` while nothing is pending. The outputs are judged every clock against the model: a new pattern must appear together with the inverted polarity on the first cycle of the next frame, and never earlier.

// File: rtl/lcd_mux_pkg.sv
// Shared level codes and the duty decode for the LCD sequencer.
package lcd_mux_pkg;
    typedef logic [1:0] lvl_t;

    localparam lvl_t LV_BOT = 2'd0;   // bottom rail
    localparam lvl_t LV_LO  = 2'd1;   // lower intermediate (also half-bias midpoint)
    localparam lvl_t LV_HI  = 2'd2;   // upper intermediate
    localparam lvl_t LV_TOP = 2'd3;   // top rail, also the blank level

    // Number of active commons for a duty code.
    function automatic logic [2:0] active_coms(input logic [1:0] duty);
        case (duty)
            2'b10:   active_coms = 3'd3;
            2'b11:   active_coms = 3'd4;
            default: active_coms = 3'd2;
        endcase
    endfunction
endpackage

// File: rtl/lcd_frame_timer.sv
// Phase and frame timer. One count per clock. A phase lasts BASE_DIV << frame_code
// clocks, a frame lasts n_act phases, and the polarity inverts at every frame end.
// Assumes n_act is between 1 and COMS. If the duty shrinks mid-frame, a phase index
// beyond the new range wraps at the next phase end.
module lcd_frame_timer #(
    parameter int BASE_DIV = 128,
    parameter int COMS     = 4,
    localparam int CNT_W   = $clog2(BASE_DIV) + 4,
    localparam int PH_W    = (COMS > 1) ? $clog2(COMS) : 1,
    localparam int NW      = $clog2(COMS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      frame_code,
    input  logic [NW-1:0]   n_act,
    output logic [PH_W-1:0] ph,
    output logic            pol,
    output logic            phase_end,
    output logic            frame_end
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] phase_len;

    // Phase length for the selected divider.
    always_comb phase_len = CNT_W'(BASE_DIV) << frame_code;

    // Phase and frame end detection.
    always_comb begin
        phase_end = (cnt >= phase_len - CNT_W'(1));
        frame_end = phase_end && (int'(ph) >= int'(n_act) - 1);
    end

    // Clock counter within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (phase_end) cnt <= '0;
        else                cnt <= cnt + CNT_W'(1);
    end

    // Phase index, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)         ph <= '0;
        else if (frame_end) ph <= '0;
        else if (phase_end) ph <= ph + PH_W'(1);
    end

    // Frame polarity, inverted once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         pol <= 1'b0;
        else if (frame_end) pol <= ~pol;
    end
endmodule

// File: rtl/lcd_out_latch.sv
// Output latch, COMS rows by SEGS bits. A load request is held pending and copies
// ram_data only in a frame-end cycle. A request that arrives in that cycle is
// applied at once. Assumes ram_data is stable in the frame-end cycle.
module lcd_out_latch #(
    parameter int COMS = 4,
    parameter int SEGS = 60,
    localparam int BITS = COMS * SEGS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            latch_req,
    input  logic            frame_end,
    input  logic [BITS-1:0] ram_data,
    output logic [BITS-1:0] lat
);
    logic pending;

    // Remember a request until the next frame end consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending <= 1'b0;
        else if (frame_end) pending <= 1'b0;
        else if (latch_req) pending <= 1'b1;
    end

    // Load the latch on a frame end that has a request behind it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                lat <= '0;
        else if (frame_end && (pending || latch_req)) lat <= ram_data;
    end
endmodule

// File: rtl/lcd_level_map.sv
// Level selection. Turns the phase, polarity, bias and latch row into a level code
// for each line. Blank forces every line to the top rail. Purely combinational.
module lcd_level_map
    import lcd_mux_pkg::*;
#(
    parameter int COMS = 4,
    parameter int SEGS = 60,
    localparam int PH_W = (COMS > 1) ? $clog2(COMS) : 1,
    localparam int NW   = $clog2(COMS + 1)
) (
    input  logic [PH_W-1:0]      ph,
    input  logic                 pol,
    input  logic [NW-1:0]        n_act,
    input  logic                 half_bias,
    input  logic                 blank,
    input  logic [COMS*SEGS-1:0] lat,
    output logic [2*COMS-1:0]    com_lvl,
    output logic [2*SEGS-1:0]    seg_lvl
);
    lvl_t com_sel, com_idle, seg_lit, seg_dark;
    logic [SEGS-1:0] row;

    // Levels for the current polarity and bias.
    always_comb begin
        com_sel  = pol ? LV_BOT : LV_TOP;
        seg_lit  = pol ? LV_TOP : LV_BOT;
        com_idle = (half_bias || !pol) ? LV_LO : LV_HI;
        if (half_bias) seg_dark = pol ? LV_BOT : LV_TOP;
        else           seg_dark = pol ? LV_LO  : LV_HI;
    end

    // Latch row shown in the current phase.
    always_comb row = lat[int'(ph) * SEGS +: SEGS];

    for (genvar c = 0; c < COMS; c++) begin : g_com
        // Common c: selected, idle, unused or blanked.
        always_comb begin
            if (blank)                                 com_lvl[2*c +: 2] = LV_TOP;
            else if (c < int'(n_act) && c == int'(ph)) com_lvl[2*c +: 2] = com_sel;
            else                                       com_lvl[2*c +: 2] = com_idle;
        end
    end

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        // Segment s: lit, dark or blanked.
        always_comb begin
            if (blank)       seg_lvl[2*s +: 2] = LV_TOP;
            else if (row[s]) seg_lvl[2*s +: 2] = seg_lit;
            else             seg_lvl[2*s +: 2] = seg_dark;
        end
    end
endmodule

// File: rtl/lcd_mux_seq.sv
// Top of the multiplexed LCD sequencer. It decodes duty and bias, then connects the
// frame timer, the output latch and the level map. Assumes clk is the oscillator
// clock and that reset is synchronous and active low.
module lcd_mux_seq
    import lcd_mux_pkg::*;
#(
    parameter int BASE_DIV = 128,
    parameter int COMS     = 4,
    parameter int SEGS     = 60,
    localparam int PH_W    = (COMS > 1) ? $clog2(COMS) : 1,
    localparam int NW      = $clog2(COMS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           duty_sel,
    input  logic [1:0]           frame_code,
    input  logic                 disp_on,
    input  logic                 disp_off_n,
    input  logic                 latch_req,
    input  logic [COMS*SEGS-1:0] ram_data,
    output logic [2*COMS-1:0]    com_lvl,
    output logic [2*SEGS-1:0]    seg_lvl
);
    logic [NW-1:0]        n_act;
    logic                 half_bias;
    logic                 blank;
    logic [PH_W-1:0]      ph;
    logic                 pol;
    logic                 phase_end;
    logic                 frame_end;
    logic [COMS*SEGS-1:0] lat;

    // Duty decode, bias choice and blanking.
    always_comb begin
        n_act     = NW'(active_coms(duty_sel));
        half_bias = (n_act == NW'(2));
        blank     = !disp_on || !disp_off_n;
    end

    lcd_frame_timer #(.BASE_DIV(BASE_DIV), .COMS(COMS)) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_code(frame_code), .n_act(n_act),
        .ph(ph), .pol(pol), .phase_end(phase_end), .frame_end(frame_end)
    );

    lcd_out_latch #(.COMS(COMS), .SEGS(SEGS)) u_latch (
        .clk(clk), .rst_n(rst_n), .latch_req(latch_req), .frame_end(frame_end),
        .ram_data(ram_data), .lat(lat)
    );

    lcd_level_map #(.COMS(COMS), .SEGS(SEGS)) u_map (
        .ph(ph), .pol(pol), .n_act(n_act), .half_bias(half_bias), .blank(blank),
        .lat(lat), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );
endmodule

// File: rtl/lcd_mux_seq_chk.sv
// Assertion checker for lcd_mux_seq, attached through bind. Watches the ports and
// the timer and latch state of the top module.
module lcd_mux_seq_chk #(
    parameter int COMS = 4,
    parameter int SEGS = 60,
    localparam int PH_W = (COMS > 1) ? $clog2(COMS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           duty_sel,
    input logic                 disp_on,
    input logic                 disp_off_n,
    input logic [2*COMS-1:0]    com_lvl,
    input logic [2*SEGS-1:0]    seg_lvl,
    input logic [PH_W-1:0]      ph,
    input logic                 pol,
    input logic                 phase_end,
    input logic                 frame_end,
    input logic [COMS*SEGS-1:0] lat
);
    logic shown;
    always_comb shown = disp_on && disp_off_n;

    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != $past(ph)) |-> $past(phase_end));

    p_pol_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pol != $past(pol)) |-> $past(frame_end));

    p_half_no_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shown && !duty_sel[1]) |-> (com_lvl[1:0] != 2'd2 && seg_lvl[1:0] != 2'd2));

    p_blank_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !shown |-> ((&com_lvl) && (&seg_lvl)));

    p_latch_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lat != $past(lat)) |-> $past(frame_end));

    p_unused_com_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shown && duty_sel != 2'b11) |-> (com_lvl[2*COMS-1 -: 2] == 2'd1 ||
                                          com_lvl[2*COMS-1 -: 2] == 2'd2));
endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(.COMS(COMS), .SEGS(SEGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .disp_on(disp_on),
    .disp_off_n(disp_off_n), .com_lvl(com_lvl), .seg_lvl(seg_lvl), .ph(ph),
    .pol(pol), .phase_end(phase_end), .frame_end(frame_end), .lat(lat)
);

// File: tb/lcd_mux_seq_tb.sv
// Bench for lcd_mux_seq. A behavioural model compared on every falling edge.
module lcd_mux_seq_tb;
    localparam int COMS = 4;
    localparam int SEGS = 60;
    localparam int BITS = COMS * SEGS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        duty_sel = 2'b00;
    logic [1:0]        frame_code = 2'b00;
    logic              disp_on = 1'b0;
    logic              disp_off_n = 1'b1;
    logic              latch_req = 1'b0;
    logic [BITS-1:0]   ram_data = '0;
    logic [2*COMS-1:0] com_lvl;
    logic [2*SEGS-1:0] seg_lvl;

    lcd_mux_seq u_dut (
        .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .frame_code(frame_code),
        .disp_on(disp_on), .disp_off_n(disp_off_n), .latch_req(latch_req),
        .ram_data(ram_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    always #10 clk = ~clk;   // 50 MHz

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R6";

    // Model state
    int m_cnt = 0, m_ph = 0, m_pol = 0, m_pend = 0;
    logic [BITS-1:0] m_lat = '0;

    function automatic int ncom(input logic [1:0] d);
        return d[1] ? (d[0] ? 4 : 3) : 2;
    endfunction

    // Model advances on each rising edge, following the requirements.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_ph = 0; m_pol = 0; m_pend = 0; m_lat = '0;
        end else begin
            int n, len;
            bit pend_end, fr_end;
            n = ncom(duty_sel);
            len = 128 << frame_code;
            pend_end = (m_cnt >= len - 1);
            fr_end = pend_end && (m_ph >= n - 1);
            if (fr_end) begin
                if (m_pend != 0 || latch_req) m_lat = ram_data;
                m_pend = 0;
                m_pol = 1 - m_pol;
            end else if (latch_req) m_pend = 1;
            if (pend_end) begin
                m_cnt = 0;
                m_ph = fr_end ? 0 : m_ph + 1;
            end else m_cnt = m_cnt + 1;
        end
    end

    // Expected outputs from the model state and the live inputs.
    task automatic expect_lvls(output logic [2*COMS-1:0] ec, output logic [2*SEGS-1:0] es);
        int n;
        bit half;
        logic [1:0] sel, idle, lit, dark;
        n = ncom(duty_sel);
        half = (n == 2);
        sel  = m_pol ? 2'd0 : 2'd3;
        lit  = m_pol ? 2'd3 : 2'd0;
        idle = (half || m_pol == 0) ? 2'd1 : 2'd2;
        dark = half ? (m_pol ? 2'd0 : 2'd3) : (m_pol ? 2'd1 : 2'd2);
        for (int c = 0; c < COMS; c++)
            ec[2*c +: 2] = (!disp_on || !disp_off_n) ? 2'd3 :
                           ((c < n && c == m_ph) ? sel : idle);
        for (int s = 0; s < SEGS; s++)
            es[2*s +: 2] = (!disp_on || !disp_off_n) ? 2'd3 :
                           (m_lat[m_ph*SEGS + s] ? lit : dark);
    endtask

    // Compare on every falling edge once reset has been applied.
    always @(negedge clk) begin
        if (!done && cycles > 1) begin
            logic [2*COMS-1:0] ec;
            logic [2*SEGS-1:0] es;
            expect_lvls(ec, es);
            compared++;
            if (com_lvl !== ec || seg_lvl !== es) begin
                mismatched++;
                $display("FAIL %s t=%0t com act=%h exp=%h seg act=%h exp=%h",
                         cur_req, $time, com_lvl, ec, seg_lvl, es);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic direct_all_top(input string tag);
        @(negedge clk); #1;
        compared++;
        if (!((&com_lvl) && (&seg_lvl))) begin
            mismatched++;
            $display("FAIL %s all-top act com=%h seg=%h exp all 3", tag, com_lvl, seg_lvl);
        end
        step(1);
    endtask

    task automatic fill_ram(input int seed);
        for (int i = 0; i < BITS; i++) ram_data[i] = (((i * 7 + seed) % 3) == 0);
    endtask

    task automatic run_frames(input int f);
        step(f * ncom(duty_sel) * (128 << frame_code));
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (!done && cycles > 150000) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog act=%0d cycles exp<150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R6: reset state, display off
        cur_req = "R6";
        fill_ram(1);
        do_reset;
        step(5);
        direct_all_top("R6");

        // R7: request mid-frame is deferred to the frame end
        cur_req = "R7";
        duty_sel = 2'b11; frame_code = 2'b00; disp_on = 1'b1;
        step(100);
        latch_req = 1'b1; step(1); latch_req = 1'b0;
        step(50);
        fill_ram(2);              // changed data, no new request: only the boundary copy counts
        run_frames(2);
        fill_ram(5);              // no request pending: no effect
        run_frames(1);

        // R4: half bias at duty 00
        cur_req = "R4";
        duty_sel = 2'b00; frame_code = 2'b01;
        do_reset;
        latch_req = 1'b1; step(1); latch_req = 1'b0;
        run_frames(3);

        // R2: duty code 01 is also two commons
        cur_req = "R2";
        duty_sel = 2'b01; frame_code = 2'b00;
        fill_ram(3); latch_req = 1'b1; step(1); latch_req = 1'b0;
        run_frames(3);

        // R8: three commons, COM3 held idle
        cur_req = "R8";
        duty_sel = 2'b10; frame_code = 2'b10;
        do_reset;
        latch_req = 1'b1; step(1); latch_req = 1'b0;
        run_frames(2);

        // R1: slowest divider at four commons
        cur_req = "R1";
        duty_sel = 2'b11; frame_code = 2'b11;
        do_reset;
        latch_req = 1'b1; step(1); latch_req = 1'b0;
        run_frames(2);

        // R3: polarity across several short frames
        cur_req = "R3";
        duty_sel = 2'b00; frame_code = 2'b00;
        do_reset;
        run_frames(4);

        // R9: request placed exactly in the frame-end cycle, with new data
        cur_req = "R9";
        duty_sel = 2'b11; frame_code = 2'b00;
        for (int k = 0; k < 3; k++) begin
            int guard;
            guard = 0;
            while (!(m_cnt == (128 << frame_code) - 1 && m_ph == ncom(duty_sel) - 1)
                   && guard < 5000) begin
                step(1);
                guard++;
            end
            fill_ram(10 + k);
            latch_req = 1'b1; step(1); latch_req = 1'b0;
            step(600);
        end

        // R5: blanking by either control, latch kept
        cur_req = "R5";
        disp_off_n = 1'b0;
        step(40);
        direct_all_top("R5");
        disp_off_n = 1'b1;
        step(40);
        disp_on = 1'b0;
        step(40);
        direct_all_top("R5");
        disp_on = 1'b1;
        run_frames(1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule